// File: doc/BRIEF.md
# Two-Stage Card Clock Generator

This block derives the clocks for the cards of a storage host controller from one fast reference clock. A first stage divides the reference by a programmable factor and has a programmable high time. Its output feeds a bank of second-stage dividers. Each of these divides by an even factor 2*M, or passes the first-stage clock through unchanged when M is zero. Every card output picks one second-stage divider as its source. Each card also has an enable bit and a low-power bit; the low-power bit gates the clock while the external idle input says that no transfer is in progress.

The settings arrive on plain configuration inputs and act as shadow values. The clocks keep running on the active copy until an update is accepted on a valid/ready handshake. The source must hold `upd_valid` and all configuration inputs stable until the cycle in which `upd_ready` is also high. The block applies back-pressure by dropping `upd_ready` for the one cycle after each accepted update. On acceptance, the first stage and all dividers restart from the start of a period.

All generated clocks are registered levels in the reference domain, so the whole block is one synchronous design.

Top module: `cardclk_gen`

## Requirements
- R1: The first stage repeats every P+1 reference cycles, where P is `cfg_p`. A requested P of 0 is applied as 1.
- R2: In each first-stage period the first H+1 cycles are high and the rest are low, where H is `cfg_h`. A requested H of P or more is applied as P-1.
- R3: A second-stage divider with nonzero M (8 bits) is low for M first-stage periods and then high for M periods, starting low at an update. This gives a divide by 2*M.
- R4: A second-stage divider with M equal to 0 follows the first-stage clock directly.
- R5: Card c takes its clock from the divider whose index equals its source field. The field is bits [2c+1:2c] of `cfg_src`, and value k selects divider k. After reset, card c uses divider c.
- R6: A card whose enable bit (bit c of `cfg_en`) is 0 outputs low. Its gate changes state only while the selected source is low, so no high pulse is cut short by gating.
- R7: A card with its low-power bit (bit c of `cfg_lp`) set outputs low while `bus_idle` is 1 and runs while it is 0. With the bit clear, `bus_idle` has no effect on that card.
- R8: Changes on the configuration inputs have no effect on any card output until an update is accepted.
- R9: An update is accepted in a cycle where `upd_valid` and `upd_ready` are both 1. `upd_ready` is 1 after reset, is 0 in the cycle after an acceptance, and is 1 again in the cycle after that.
- R10: Let cycle 0 be the first cycle after the accepting edge. The card output in cycle t is the selected source level of cycle t-1, with that source restarted from phase zero in cycle 0.
- R11: Reset sets every card output low and makes the active settings P=3, H=1, every M=0, all cards disabled and low-power off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update request; configuration inputs held stable while high |
| upd_ready | output | 1 | Update can be accepted this cycle |
| cfg_p | input | 4 | First-stage divide setting (period P+1) |
| cfg_h | input | 4 | First-stage high-time setting (H+1 cycles) |
| cfg_m | input | 32 | Second-stage factors, 8 bits per divider, divider d at [8d+7:8d] |
| cfg_src | input | 4 | Per-card divider select, 2 bits per card |
| cfg_en | input | 2 | Per-card clock enable |
| cfg_lp | input | 2 | Per-card low-power gating enable |
| bus_idle | input | 1 | High while no command or data transfer is in progress |
| card_clk | output | 2 | Card clock outputs |

## Verification
The bench goes after the clamp cases, P of 0 and H at or above P. A design that skipped the clamp would stall the first stage or hold it high, and the card outputs would stop toggling. It drives the largest factor, 255, and the bypass value 0. It also routes cards to dividers other than their own, where a wrong mux would show another divider's period. Configuration inputs are changed without an update to catch settings that leak through early. The bench also checks low-power gating with the idle input high and low. A gate that was not held while the source is high, or that ignored the idle input, would leave the output running or clip pulses.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  localparam int unsigned CCG_PW = 4;
  localparam int unsigned CCG_MW = 8;

  // First-stage factor actually applied: zero is raised to one.
  function automatic int unsigned eff_p(int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction

  // High time actually applied: always leaves at least one low cycle.
  function automatic int unsigned eff_h(int unsigned h, int unsigned pe);
    return (h >= pe) ? pe - 1 : h;
  endfunction

endpackage

// File: rtl/ccg_stage1.sv
module ccg_stage1 #(
  parameter int unsigned PW = ccg_pkg::CCG_PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply_i,
  input  logic [PW-1:0] p_i,
  input  logic [PW-1:0] h_i,
  output logic          lvl_o,
  output logic          end_o
);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || apply_i) phase_q <= '0;
    else if (phase_q == p_i) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign lvl_o = (phase_q <= h_i);
  assign end_o = (phase_q == p_i);

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= p_i);

  // R2
  period_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> !lvl_o);

endmodule

// File: rtl/ccg_div2m.sv
module ccg_div2m #(
  parameter int unsigned MW = ccg_pkg::CCG_MW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply_i,
  input  logic [MW-1:0] m_i,
  input  logic          s1_lvl_i,
  input  logic          s1_end_i,
  output logic          lvl_o
);

  logic [MW-1:0] per_q;
  logic          tog_q;
  logic          bypass;

  assign bypass = (m_i == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || apply_i) begin
      per_q <= '0;
      tog_q <= 1'b0;
    end else if (s1_end_i && !bypass) begin
      if (per_q == MW'(m_i - 1'b1)) begin
        per_q <= '0;
        tog_q <= ~tog_q;
      end else begin
        per_q <= per_q + 1'b1;
      end
    end
  end

  assign lvl_o = bypass ? s1_lvl_i : tog_q;

  // R3
  toggle_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog_q) |-> $past(s1_end_i || apply_i));

endmodule

// File: rtl/ccg_cgate.sv
module ccg_cgate (
  input  logic clk,
  input  logic rst_n,
  input  logic src_lvl_i,
  input  logic en_i,
  input  logic lp_i,
  input  logic idle_i,
  output logic clk_o
);

  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      clk_o  <= 1'b0;
    end else begin
      if (!src_lvl_i) open_q <= en_i & ~(lp_i & idle_i);
      clk_o <= src_lvl_i & open_q;
    end
  end

  // R6
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_lvl_i && $past(src_lvl_i)) |-> $stable(open_q));

  // R6
  no_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_o) && $past(src_lvl_i) && src_lvl_i) |=> clk_o);

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen #(
  parameter int unsigned PW    = ccg_pkg::CCG_PW,
  parameter int unsigned MW    = ccg_pkg::CCG_MW,
  parameter int unsigned NDIV  = 4,
  parameter int unsigned NCARD = 2,
  localparam int unsigned SW   = (NDIV > 1) ? $clog2(NDIV) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_valid,
  output logic                  upd_ready,
  input  logic [PW-1:0]         cfg_p,
  input  logic [PW-1:0]         cfg_h,
  input  logic [NDIV*MW-1:0]    cfg_m,
  input  logic [NCARD*SW-1:0]   cfg_src,
  input  logic [NCARD-1:0]      cfg_en,
  input  logic [NCARD-1:0]      cfg_lp,
  input  logic                  bus_idle,
  output logic [NCARD-1:0]      card_clk
);

  logic                       acc;
  logic [PW-1:0]              act_p, act_h;
  logic [NDIV-1:0][MW-1:0]    act_m;
  logic [NCARD-1:0][SW-1:0]   act_src;
  logic [NCARD-1:0]           act_en, act_lp;
  logic                       ready_q;
  logic                       s1_lvl, s1_end;
  logic [NDIV-1:0]            div_lvl;
  logic [NCARD-1:0]           card_src_lvl;
  int unsigned                new_p;

  assign acc       = upd_valid & ready_q;
  assign upd_ready = ready_q;
  assign new_p     = ccg_pkg::eff_p(int'(cfg_p));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      act_p   <= PW'(3);
      act_h   <= PW'(1);
      act_m   <= '0;
      act_en  <= '0;
      act_lp  <= '0;
      for (int c = 0; c < NCARD; c++) act_src[c] <= SW'(c % NDIV);
    end else begin
      ready_q <= ~acc;
      if (acc) begin
        act_p  <= PW'(new_p);
        act_h  <= PW'(ccg_pkg::eff_h(int'(cfg_h), new_p));
        act_en <= cfg_en;
        act_lp <= cfg_lp;
        for (int d = 0; d < NDIV; d++) act_m[d] <= cfg_m[d*MW +: MW];
        for (int c = 0; c < NCARD; c++) act_src[c] <= cfg_src[c*SW +: SW];
      end
    end
  end

  ccg_stage1 #(.PW(PW)) stage1_i (
    .clk(clk), .rst_n(rst_n), .apply_i(acc),
    .p_i(act_p), .h_i(act_h), .lvl_o(s1_lvl), .end_o(s1_end)
  );

  for (genvar d = 0; d < NDIV; d++) begin : g_div
    ccg_div2m #(.MW(MW)) div_i (
      .clk(clk), .rst_n(rst_n), .apply_i(acc), .m_i(act_m[d]),
      .s1_lvl_i(s1_lvl), .s1_end_i(s1_end), .lvl_o(div_lvl[d])
    );
  end

  for (genvar c = 0; c < NCARD; c++) begin : g_card
    assign card_src_lvl[c] = div_lvl[act_src[c]];
    ccg_cgate gate_i (
      .clk(clk), .rst_n(rst_n), .src_lvl_i(card_src_lvl[c]),
      .en_i(act_en[c]), .lp_i(act_lp[c]), .idle_i(bus_idle),
      .clk_o(card_clk[c])
    );
  end

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !upd_ready);

  // R9
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_ready |=> upd_ready);

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(act_p) && $stable(act_h) && $stable(act_m)
              && $stable(act_src) && $stable(act_en) && $stable(act_lp)));

endmodule

// File: tb/cardclk_gen_tb.sv
`timescale 1ns/1ps
module cardclk_gen_tb_top;
  localparam int NC = 2, ND = 4, MW = 8, PW = 4, SW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, upd_valid, upd_ready, bus_idle;
  logic [PW-1:0] cfg_p, cfg_h;
  logic [ND*MW-1:0] cfg_m;
  logic [NC*SW-1:0] cfg_src;
  logic [NC-1:0] cfg_en, cfg_lp, card_clk;

  cardclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .cfg_p(cfg_p), .cfg_h(cfg_h), .cfg_m(cfg_m), .cfg_src(cfg_src),
    .cfg_en(cfg_en), .cfg_lp(cfg_lp), .bus_idle(bus_idle), .card_clk(card_clk)
  );

  int n_cmp = 0, n_bad = 0, t = 0;
  bit done = 0;
  int ap_pe, ap_he;
  int ap_m[ND];
  int ap_src[NC];

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0d", req, act, exp, t);
    end
  endtask

  function automatic int src_lvl(int tt, int pe, int he, int m);
    int k = tt % (pe + 1);
    int n = tt / (pe + 1);
    if (m == 0) return (k <= he) ? 1 : 0;
    return ((n / m) % 2 == 1) ? 1 : 0;
  endfunction

  function automatic int card_period(int c);
    int m = ap_m[ap_src[c]];
    return ((m == 0) ? 1 : 2 * m) * (ap_pe + 1);
  endfunction

  function automatic int settle();
    int s = 0;
    for (int c = 0; c < NC; c++) if (card_period(c) > s) s = card_period(c);
    return s + 2;
  endfunction

  task automatic set_cfg(int p, int h, int m0, int m1, int m2, int m3,
                         int s0, int s1, int en, int lp);
    cfg_p = PW'(p); cfg_h = PW'(h);
    cfg_m = {MW'(m3), MW'(m2), MW'(m1), MW'(m0)};
    cfg_src = {SW'(s1), SW'(s0)};
    cfg_en = NC'(en); cfg_lp = NC'(lp);
  endtask

  // R9 / R10: drive an update, land in cycle 0 after the accepting edge
  task automatic do_apply();
    @(negedge clk);
    chk("R9 ready before accept", upd_ready, 1);
    upd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    t = 0;
    ap_pe = (cfg_p == 0) ? 1 : int'(cfg_p);
    ap_he = (int'(cfg_h) >= ap_pe) ? ap_pe - 1 : int'(cfg_h);
    for (int d = 0; d < ND; d++) ap_m[d] = int'(cfg_m[d*MW +: MW]);
    for (int c = 0; c < NC; c++) ap_src[c] = int'(cfg_src[c*SW +: SW]);
    chk("R9 ready low after accept", upd_ready, 0);
  endtask

  // R10: card output in cycle t equals source level of cycle t-1
  task automatic watch(string req, int skip, int win, bit [NC-1:0] low_mask);
    for (int i = 0; i < skip + win; i++) begin
      if (t == 1) chk("R9 ready restored", upd_ready, 1);
      if (i >= skip && t >= 1)
        for (int c = 0; c < NC; c++)
          chk(req, card_clk[c], low_mask[c] ? 0 :
              src_lvl(t - 1, ap_pe, ap_he, ap_m[ap_src[c]]));
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1C));
    rst_n = 0; upd_valid = 0; bus_idle = 0;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R11: reset state, cards disabled
    chk("R11 ready after reset", upd_ready, 1);
    for (int i = 0; i < 20; i++) begin
      chk("R11 card clocks low", int'(card_clk), 0);
      @(negedge clk);
    end

    // R4 bypass on card0, R3 divide by 4 on card1
    set_cfg(3, 1, 0, 2, 0, 0, 0, 1, 3, 0);
    do_apply();
    watch("R3 R4 R10 directed", settle(), 80, 2'b00);

    // R8: change inputs without an update, clocks keep the old settings
    set_cfg(7, 2, 3, 5, 1, 1, 2, 3, 0, 3);
    bus_idle = 1;
    watch("R8 shadow held", 0, 100, 2'b00);
    bus_idle = 0;

    // R1 / R2 clamps: P=0 -> 1, H>=P -> P-1
    set_cfg(0, 5, 0, 0, 0, 0, 0, 1, 3, 0);
    do_apply();
    watch("R1 R2 clamp P0", settle(), 40, 2'b00);
    set_cfg(5, 9, 0, 1, 0, 0, 0, 1, 3, 0);
    do_apply();
    watch("R2 clamp H", settle(), 60, 2'b00);

    // R5: cards routed to other dividers
    set_cfg(2, 0, 1, 1, 3, 4, 3, 2, 3, 0);
    do_apply();
    watch("R5 source select", settle(), 120, 2'b00);

    // R3 boundary: M=255
    set_cfg(1, 0, 255, 0, 0, 0, 0, 1, 3, 0);
    do_apply();
    watch("R3 M255", settle(), 1100, 2'b00);

    // R6: card1 disabled
    set_cfg(3, 1, 1, 2, 0, 0, 0, 1, 1, 0);
    do_apply();
    watch("R6 disabled low", settle(), 80, 2'b10);

    // R7: low-power gating with idle high, then idle low
    set_cfg(3, 1, 1, 0, 0, 0, 0, 1, 3, 3);
    bus_idle = 1;
    do_apply();
    watch("R7 idle gated", settle(), 60, 2'b11);
    bus_idle = 0;
    watch("R7 busy runs", settle(), 60, 2'b00);
    // R7: low-power off ignores idle
    set_cfg(3, 1, 1, 0, 0, 0, 0, 1, 3, 0);
    bus_idle = 1;
    do_apply();
    watch("R7 lp off ignores idle", settle(), 60, 2'b00);
    bus_idle = 0;

    // constrained random settings
    for (int r = 0; r < 12; r++) begin
      set_cfg($urandom % 16, $urandom % 16, $urandom % 6, $urandom % 6,
              $urandom % 6, $urandom % 6, $urandom % 4, $urandom % 4,
              3, $urandom % 4);
      do_apply();
      watch("R3 R4 R5 R10 random", settle(), 150, 2'b00);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule